// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the command front end and storage of a small serial nonvolatile memory. A host reaches it over three pins: chip select, serial clock and serial data-in. It answers on one data-out pin, which comes with an output-enable so that the pad can be tri-stated. A transaction begins with a start bit. A 2-bit opcode follows, then a word address, then write data when the opcode needs it. The block reads, writes and erases single words. It can also erase or write the whole array at once, and it can lock and unlock programming. While a program cycle runs, the host can poll data-out for ready/busy.

All pins are sampled in the system clock domain. Chip select, serial clock and data-in pass through a synchronizer. Each serial clock phase must last at least three system clock periods. The array is a byte-wide RAM with registered reads. An organization input selects the word size. In wide mode the words are 16 bits and the word address is ADDR_W16 bits. In narrow mode the words are 8 bits and the address is ADDR_W16+1 bits. A power-good input stands in for supply monitoring. A fixed busy counter stands in for real cell programming time.

Top module: `tw_serial_mem`

## Requirements
- R1: After reset, sdo_en is low and programming is locked: a write sent before any unlock command leaves the array unchanged.
- R2: A start bit is the first serial clock rise at which cs and sdi are both high. Clock rises with cs low, and zero bits with cs high before the start bit, cause no operation.
- R3: sdo_en is high only while read data is being shifted out or while ready/busy status is shown. It goes low within three clocks of cs falling, and stays low during opcode, address and data input.
- R4: Read uses opcode 10. At the serial clock rise that takes the last address bit, data-out shows one 0 bit. Each following rise shifts out one word bit, MSB first. Reading continues through successive addresses, and the address wraps from the last word to word 0.
- R5: Write uses opcode 01. When the block is unlocked, the word shifted in after the address is stored at that address.
- R6: Erase uses opcode 11. When the block is unlocked, it sets every bit of the addressed word to 1.
- R7: With opcode 00, the top two address bits select a sub-command. Pattern 10 erases the whole array to all ones. Pattern 01 writes the data word that follows into every word.
- R8: With opcode 00, pattern 11 unlocks programming and pattern 00 locks it. While locked, write, erase and the whole-array commands have no effect.
- R9: While pwr_ok is low, no program cycle starts and the unlock state is cleared. Programming stays locked after pwr_ok returns, until a new unlock command is sent.
- R10: A program command starts when cs falls after its last bit, and the block then stays busy for at least BUSY_CYC clocks. If cs is raised while busy, data-out is driven low. Once the program cycle ends, data-out is driven high, until the next start bit.
- R11: org_wide high selects 16-bit words and ADDR_W16 address bits. org_wide low selects 8-bit words and ADDR_W16+1 address bits. In narrow mode, byte address 2a+1 is the low byte of wide word a, and byte address 2a is its high byte.
- R12: If cs falls before a command's last bit, the command is dropped. Bits clocked in after the last required bit of a non-read command are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply good; low blocks programming and clears the unlock state |
| org_wide | input | 1 | Word organization: 1 = 16-bit, 0 = 8-bit |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo_data | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for data-out; low means high impedance |

## Verification
The bench first fills the whole array with a known pattern, then reads it back across the top of the address space. This shows that auto-increment wraps to word 0 rather than running past the end. Single-word write and erase are each followed by a read of the neighbouring words, which catches byte-lane and parity mistakes in wide mode. The same storage is then accessed in narrow mode, which checks the byte mapping between the two organizations. Commands are tried locked, unlocked, with power-good low, cut short by chip select, and padded with extra trailing bits. This separates gating faults from decode faults. A timed status poll checks that busy is reported for the whole program window and that ready is reported after it.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_RD,
    ST_END
  } fe_state_t;

  typedef enum logic [2:0] {
    JOB_NONE,
    JOB_WRITE,
    JOB_ERASE,
    JOB_ERAL,
    JOB_WRAL
  } job_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_WRAL   = 2'b01;
  localparam logic [1:0] EXT_ERAL   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tws_ram.sv
module tws_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tws_prog.sv
module tws_prog #(
  parameter int BW       = 7,
  parameter int BUSY_CYC = 160
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [BW-1:0] job_base,
  input  logic [BW:0]   job_n,
  input  logic [7:0]    job_hi,
  input  logic [7:0]    job_lo,
  output logic          busy,
  output logic          we,
  output logic [BW-1:0] waddr,
  output logic [7:0]    wdata
);

  localparam int BCW = $clog2(BUSY_CYC + 1);

  logic [BCW-1:0] bcnt;
  logic [BW:0]    idx;
  logic [BW:0]    n_q;
  logic [BW-1:0]  base_q;
  logic [7:0]     hi_q;
  logic [7:0]     lo_q;
  logic           more;

  assign more = idx < n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      bcnt   <= '0;
      idx    <= '0;
      n_q    <= '0;
      base_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (!busy) begin
      if (go) begin
        busy   <= 1'b1;
        bcnt   <= BCW'(BUSY_CYC - 1);
        idx    <= '0;
        n_q    <= job_n;
        base_q <= job_base;
        hi_q   <= job_hi;
        lo_q   <= job_lo;
      end
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (more) idx <= idx + 1'b1;
      if (bcnt == '0 && !more) busy <= 1'b0;
    end
  end

  assign we    = busy && more;
  assign waddr = base_q + idx[BW-1:0];
  assign wdata = idx[0] ? lo_q : hi_q;

endmodule

// File: rtl/tws_front.sv
module tws_front
  import tws_pkg::*;
#(
  parameter int A16 = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_s,
  input  logic         sck_s,
  input  logic         di_s,
  input  logic         org_w,
  input  logic         pwr_ok,
  input  logic         busy,
  input  logic [7:0]   rd_q,
  output logic [A16:0] rd_addr,
  output logic         go,
  output logic [A16:0] job_base,
  output logic [A16+1:0] job_n,
  output logic [7:0]   job_hi,
  output logic [7:0]   job_lo,
  output logic         wen,
  output logic         sdo_en,
  output logic         sdo_data
);

  localparam int A8 = A16 + 1;
  localparam int CW = $clog2((A8 > 16 ? A8 : 16) + 1);

  fe_state_t    state;
  job_t         pend;
  logic         cs_q, sck_q, rise, cs_fall;
  logic [CW-1:0] cnt;
  logic [1:0]   opc;
  logic [A8-1:0] adr, nxt_adr;
  logic [15:0]  dat;
  logic [7:0]   sh;
  logic [2:0]   rcnt;
  logic [A8-1:0] bp;
  logic         stat;
  logic [CW-1:0] aw_m1, dw_m1;
  logic [1:0]   top2;
  logic         bulk, ones;

  assign rise    = sck_s & ~sck_q;
  assign cs_fall = cs_q & ~cs_s;
  assign aw_m1   = org_w ? CW'(A16 - 1) : CW'(A8 - 1);
  assign dw_m1   = org_w ? CW'(15) : CW'(7);
  assign nxt_adr = {adr[A8-2:0], di_s};
  assign top2    = org_w ? nxt_adr[A16-1 -: 2] : nxt_adr[A8-1 -: 2];
  assign bulk    = (pend == JOB_ERAL) || (pend == JOB_WRAL);
  assign ones    = (pend == JOB_ERAL) || (pend == JOB_ERASE);
  assign rd_addr = bp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= JOB_NONE;
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      cnt      <= '0;
      opc      <= '0;
      adr      <= '0;
      dat      <= '0;
      sh       <= '0;
      rcnt     <= '0;
      bp       <= '0;
      stat     <= 1'b0;
      wen      <= 1'b0;
      go       <= 1'b0;
      job_base <= '0;
      job_n    <= '0;
      job_hi   <= '0;
      job_lo   <= '0;
      sdo_en   <= 1'b0;
      sdo_data <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
      go    <= 1'b0;
      if (!cs_s) begin
        if (cs_fall && state == ST_END && pend != JOB_NONE && wen && pwr_ok && !busy) begin
          go       <= 1'b1;
          stat     <= 1'b1;
          job_base <= bulk ? '0 : (org_w ? {adr[A16-1:0], 1'b0} : adr);
          job_n    <= bulk ? {1'b1, {A8{1'b0}}} : (org_w ? (A8+1)'(2) : (A8+1)'(1));
          job_hi   <= ones ? 8'hFF : (org_w ? dat[15:8] : dat[7:0]);
          job_lo   <= ones ? 8'hFF : dat[7:0];
        end
        state  <= ST_IDLE;
        pend   <= JOB_NONE;
        sdo_en <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            sdo_en   <= stat;
            sdo_data <= ~busy;
            if (rise && di_s && !busy) begin
              state  <= ST_OPC;
              cnt    <= CW'(1);
              stat   <= 1'b0;
              sdo_en <= 1'b0;
            end
          end
          ST_OPC: begin
            sdo_en <= 1'b0;
            if (rise) begin
              opc <= {opc[0], di_s};
              if (cnt == '0) begin
                state <= ST_ADR;
                cnt   <= aw_m1;
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
          ST_ADR: begin
            sdo_en <= 1'b0;
            if (rise) begin
              adr <= nxt_adr;
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else begin
                case (opc)
                  OPC_READ: begin
                    state    <= ST_RD;
                    sdo_en   <= 1'b1;
                    sdo_data <= 1'b0;
                    rcnt     <= '0;
                    bp       <= org_w ? {nxt_adr[A16-1:0], 1'b0} : nxt_adr;
                  end
                  OPC_WRITE: begin
                    state <= ST_DAT;
                    cnt   <= dw_m1;
                  end
                  OPC_ERASE: begin
                    state <= ST_END;
                    pend  <= JOB_ERASE;
                  end
                  default: begin
                    case (top2)
                      EXT_UNLOCK: begin
                        if (pwr_ok) wen <= 1'b1;
                        state <= ST_END;
                      end
                      EXT_LOCK: begin
                        wen   <= 1'b0;
                        state <= ST_END;
                      end
                      EXT_ERAL: begin
                        state <= ST_END;
                        pend  <= JOB_ERAL;
                      end
                      default: begin
                        state <= ST_DAT;
                        cnt   <= dw_m1;
                      end
                    endcase
                  end
                endcase
              end
            end
          end
          ST_DAT: begin
            sdo_en <= 1'b0;
            if (rise) begin
              dat <= {dat[14:0], di_s};
              if (cnt == '0) begin
                state <= ST_END;
                pend  <= (opc == OPC_WRITE) ? JOB_WRITE : JOB_WRAL;
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
          ST_RD: begin
            sdo_en <= 1'b1;
            if (rise) begin
              if (rcnt == '0) begin
                sdo_data <= rd_q[7];
                sh       <= {rd_q[6:0], 1'b0};
                rcnt     <= 3'd7;
                bp       <= bp + 1'b1;
              end else begin
                sdo_data <= sh[7];
                sh       <= {sh[6:0], 1'b0};
                rcnt     <= rcnt - 1'b1;
              end
            end
          end
          default: begin
            sdo_en <= 1'b0;
          end
        endcase
      end
      if (!pwr_ok) wen <= 1'b0;
    end
  end

endmodule

// File: rtl/tw_serial_mem.sv
module tw_serial_mem #(
  parameter int ADDR_W16    = 6,
  parameter int BUSY_CYC    = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic org_wide,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo_data,
  output logic sdo_en
);

  localparam int BW = ADDR_W16 + 1;

  logic          cs_s, sck_s, di_s;
  logic          busy, go, we;
  logic [BW-1:0] rd_addr, waddr, job_base;
  logic [BW:0]   job_n;
  logic [7:0]    rd_q, wdata, job_hi, job_lo;
  logic          wen;

  tws_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs, sck, sdi}),
    .q   ({cs_s, sck_s, di_s})
  );

  tws_front #(.A16(ADDR_W16)) i_front (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .di_s     (di_s),
    .org_w    (org_wide),
    .pwr_ok   (pwr_ok),
    .busy     (busy),
    .rd_q     (rd_q),
    .rd_addr  (rd_addr),
    .go       (go),
    .job_base (job_base),
    .job_n    (job_n),
    .job_hi   (job_hi),
    .job_lo   (job_lo),
    .wen      (wen),
    .sdo_en   (sdo_en),
    .sdo_data (sdo_data)
  );

  tws_prog #(.BW(BW), .BUSY_CYC(BUSY_CYC)) i_prog (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .job_base (job_base),
    .job_n    (job_n),
    .job_hi   (job_hi),
    .job_lo   (job_lo),
    .busy     (busy),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata)
  );

  tws_ram #(.AW(BW), .DW(8)) i_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rd_q)
  );

endmodule

// File: rtl/tw_serial_mem_chk.sv
module tw_serial_mem_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic sdo_en,
  input logic sdo_data,
  input logic busy,
  input logic go,
  input logic wen,
  input logic pwr_ok
);

  // R3
  cs_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_en);

  // R3
  drive_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_en |-> $past(cs_s));

  // R9
  pwr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !wen);

  // R8
  prog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> ($past(wen) && $past(pwr_ok)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

  // R10
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && sdo_en) |-> !sdo_data);

endmodule

bind tw_serial_mem tw_serial_mem_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_s     (cs_s),
  .sdo_en   (sdo_en),
  .sdo_data (sdo_data),
  .busy     (busy),
  .go       (go),
  .wen      (wen),
  .pwr_ok   (pwr_ok)
);

// File: tb/test_tw_serial_mem.sv
module test_tw_serial_mem;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b1;
  logic org_wide = 1'b1;
  logic cs = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo_data, sdo_en;

  int checks = 0;
  int fails  = 0;
  int lowcnt = 0;

  logic [7:0] mem_m [128];
  bit wen_m = 1'b0;

  always #4 clk = ~clk;

  tw_serial_mem i_tw_serial_mem (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .org_wide(org_wide),
    .cs(cs), .sck(sck), .sdi(sdi), .sdo_data(sdo_data), .sdo_en(sdo_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3: per-clock reference: cs held low => output released
  always @(negedge clk) begin
    if (rst || cs) lowcnt = 0;
    else if (lowcnt < 10) lowcnt++;
    if (lowcnt >= 5) check(sdo_en == 1'b0, "R3 released while deselected", {31'd0, sdo_en}, 32'd0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int aw();
    return org_wide ? 6 : 7;
  endfunction
  function automatic int dw();
    return org_wide ? 16 : 8;
  endfunction
  function automatic logic [15:0] word_m(input int a);
    if (org_wide) return {mem_m[(2*a) % 128], mem_m[(2*a+1) % 128]};
    return {8'h00, mem_m[a % 128]};
  endfunction

  task automatic sbit(input logic d, output logic oe, output logic q);
    sdi = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    oe = sdo_en;
    q  = sdo_data;
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic oe, q;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(v[i], oe, q);
      check(oe == 1'b0, "R3 quiet during input", {31'd0, oe}, 32'd0);
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk);
    cs = 1'b0;
    sdi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_ready();
    cs_on();
    if (sdo_en) begin
      for (int i = 0; i < 400 && sdo_data == 1'b0; i++) @(negedge clk);
    end
    cs_off();
  endtask

  task automatic run_cmd(input logic [1:0] op, input int addr, input logic [15:0] d,
                         input bit has_d, input int extra);
    cs_on();
    send(32'd1, 1);
    send({30'd0, op}, 2);
    send(addr, aw());
    if (has_d) send({16'd0, d}, dw());
    if (extra > 0) send('1, extra);
    cs_off();
    wait_ready();
  endtask

  function automatic int ext(input logic [1:0] p);
    return int'(p) << (aw() - 2);
  endfunction

  task automatic unlock();
    run_cmd(2'b00, ext(2'b11), 16'h0, 1'b0, 0);
    if (pwr_ok) wen_m = 1'b1;
  endtask

  task automatic lock();
    run_cmd(2'b00, ext(2'b00), 16'h0, 1'b0, 0);
    wen_m = 1'b0;
  endtask

  task automatic write_word(input int a, input logic [15:0] d, input int extra);
    run_cmd(2'b01, a, d, 1'b1, extra);
    if (wen_m && pwr_ok) begin
      if (org_wide) begin
        mem_m[2*a] = d[15:8];
        mem_m[2*a+1] = d[7:0];
      end else mem_m[a] = d[7:0];
    end
  endtask

  task automatic erase_word(input int a);
    run_cmd(2'b11, a, 16'h0, 1'b0, 0);
    if (wen_m && pwr_ok) begin
      if (org_wide) begin
        mem_m[2*a] = 8'hFF;
        mem_m[2*a+1] = 8'hFF;
      end else mem_m[a] = 8'hFF;
    end
  endtask

  task automatic fill_all(input bit erase, input logic [15:0] d);
    if (erase) run_cmd(2'b00, ext(2'b10), 16'h0, 1'b0, 0);
    else run_cmd(2'b00, ext(2'b01), d, 1'b1, 0);
    if (wen_m && pwr_ok) begin
      for (int i = 0; i < 128; i++)
        mem_m[i] = erase ? 8'hFF : (org_wide ? ((i % 2) ? d[7:0] : d[15:8]) : d[7:0]);
    end
  endtask

  task automatic read_words(input int a, input int n, input string req);
    logic oe, q;
    logic [15:0] v;
    int words;
    words = org_wide ? 64 : 128;
    cs_on();
    send(32'd1, 1);
    send(32'd2, 2);
    send(a >> 1, aw() - 1);
    sbit(a[0], oe, q);
    check(oe == 1'b1 && q == 1'b0, "R4 dummy zero", {30'd0, oe, q}, 32'd2);
    for (int w = 0; w < n; w++) begin
      v = '0;
      for (int b = 0; b < dw(); b++) begin
        sbit(1'b0, oe, q);
        v = {v[14:0], q};
      end
      check(v == word_m((a + w) % words), req, {16'd0, v}, {16'd0, word_m((a + w) % words)});
    end
    cs_off();
  endtask

  initial begin
    logic oe, q;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(sdo_en == 1'b0, "R1 reset output off", {31'd0, sdo_en}, 32'd0);

    // R2: clock activity with cs low, then leading zeros, then a real unlock
    sdi = 1'b1;
    repeat (2) begin
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    sdi = 1'b0;
    cs_on();
    send(32'd0, 3);
    send(32'd1, 1);
    send(32'd0, 2);
    send(ext(2'b11), aw());
    cs_off();
    wen_m = 1'b1;
    fill_all(1'b1, 16'h0);
    read_words(0, 2, "R2 R7 erase-all after start with leading zeros");

    // R4 R5: writes and wrapping read
    write_word(63, 16'hA5C3, 0);
    write_word(0, 16'h5A3C, 0);
    read_words(63, 3, "R4 R5 wrap read");

    // R6
    write_word(5, 16'h1357, 0);
    write_word(6, 16'h2468, 0);
    erase_word(5);
    read_words(4, 3, "R6 erase one word");

    // R7 write-all
    fill_all(1'b0, 16'h1234);
    read_words(10, 2, "R7 write-all pattern");

    // R10 busy/ready timing
    write_word_nowait(7, 16'h0F0F);
    repeat (14) @(negedge clk);
    cs = 1'b1;
    repeat (10) @(negedge clk);
    check(sdo_en == 1'b1 && sdo_data == 1'b0, "R10 busy shown", {30'd0, sdo_en, sdo_data}, 32'd2);
    repeat (120) @(negedge clk);
    check(sdo_en == 1'b1 && sdo_data == 1'b0, "R10 still busy", {30'd0, sdo_en, sdo_data}, 32'd2);
    repeat (25) @(negedge clk);
    check(sdo_en == 1'b1 && sdo_data == 1'b1, "R10 ready shown", {30'd0, sdo_en, sdo_data}, 32'd3);
    cs_off();
    read_words(7, 1, "R10 program result");

    // R8 lock blocks writes
    lock();
    write_word(7, 16'h0000, 0);
    erase_word(7);
    read_words(7, 1, "R8 locked write and erase ignored");

    // R1 reset relocks
    unlock();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    wen_m = 1'b0;
    repeat (3) @(negedge clk);
    write_word(7, 16'hDEAD, 0);
    read_words(7, 1, "R1 locked after reset");

    // R9 power-good
    unlock();
    pwr_ok = 1'b0;
    wen_m = 1'b0;
    write_word(8, 16'hBEEF, 0);
    pwr_ok = 1'b1;
    write_word(8, 16'hBEEF, 0);
    read_words(8, 1, "R9 power low blocks and relocks");
    unlock();
    write_word(8, 16'hBEEF, 0);
    read_words(8, 1, "R9 unlocked after power return");

    // R12 aborted command and trailing bits
    cs_on();
    send(32'd1, 1);
    send(32'd1, 2);
    send(32'd9, aw());
    send(32'h00AB, 8);
    cs_off();
    wait_ready();
    read_words(9, 1, "R12 aborted write ignored");
    write_word(2, 16'hC0DE, 5);
    read_words(2, 1, "R12 trailing bits ignored");

    // R11 narrow organization
    org_wide = 1'b0;
    write_word(11, 16'h003C, 0);
    read_words(11, 1, "R11 narrow byte");
    read_words(127, 2, "R11 R4 narrow wrap");
    org_wide = 1'b1;
    read_words(5, 1, "R11 narrow byte is low half of wide word");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic write_word_nowait(input int a, input logic [15:0] d);
    cs_on();
    send(32'd1, 1);
    send(32'd1, 2);
    send(a, aw());
    send({16'd0, d}, dw());
    @(negedge clk);
    cs = 1'b0;
    sdi = 1'b0;
    if (wen_m && pwr_ok) begin
      mem_m[2*a] = d[15:8];
      mem_m[2*a+1] = d[7:0];
    end
  endtask

endmodule